// File: doc/BRIEF.md
# Branch Target and Count Unit

This block sits beside the fetch stage of an integer core. For each branch it works out where fetch goes next and whether it goes there. It also owns two architectural registers: a return-address register, here called link, and a loop counter, here called count. A branch chooses its destination from one of four sources: the immediate as an absolute address, the immediate as an offset from the branch's own address, the link register, or the count register. In the same cycle the branch may step the counter down by one and require the stepped value to be zero or nonzero before it counts as taken.

Whether the condition bits of the branch are met is settled outside this block and arrives on a single input. The taken decision and the target are combinational in the branch cycle. Updates to the link and count registers take effect at the next clock edge. Software loads either register through a one-word write port.

Top module: `branch_unit`

## Requirements
- R1: With source select 0 (absolute), the target is the immediate with its two low bits cleared.
- R2: With source select 1 (relative), the target is the branch address plus the immediate, modulo 2^AW, with its two low bits cleared.
- R3: With source select 2, the target is the current link register value with its two low bits cleared.
- R4: With source select 3, the target is the current count register value with its two low bits cleared.
- R5: The two low bits of the target output are always zero.
- R6: A valid branch with the link flag set loads link with the branch address plus 4 at the next edge, whether or not the branch is taken.
- R7: A valid branch with the decrement flag set and a source select other than 3 lowers count by one at the next edge, whether or not it is taken.
- R8: Count test select 1 requires the count value after any decrement to be zero. Select 2 requires it to be nonzero. Selects 0 and 3 apply no count test. Without a decrement, the current count value is tested.
- R9: With source select 3, the decrement flag is ignored. Count stays unchanged, and any count test uses the current value.
- R10: The taken output is high exactly when the branch is valid, the external condition is high and the count test passes. With the valid input low, the link and count registers keep their values.
- R11: A software write (sw_sel 0 selects link, 1 selects count) loads that register at the next edge. If a branch updates the same register in the same cycle, the branch value wins.
- R12: Reset clears link and count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch is presented this cycle |
| br_pc | input | AW | Address of the branch instruction |
| br_imm | input | AW | Sign-extended immediate |
| br_src | input | 2 | Target source: 0 absolute, 1 relative, 2 link, 3 count |
| br_dec | input | 1 | Decrement the count register |
| br_cond | input | 2 | Count test: 1 zero, 2 nonzero, else none |
| br_link | input | 1 | Save branch address plus 4 in link |
| br_ext | input | 1 | External branch condition |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 1 | Software write target: 0 link, 1 count |
| sw_data | input | AW | Software write data |
| br_taken | output | 1 | Branch taken decision |
| br_target | output | AW | Next fetch address |
| link_q | output | AW | Current link register |
| count_q | output | AW | Current count register |

## Verification
The taken decision and the target depend only on inputs and on the register values held before the edge, so they are due in the same cycle as the branch. The bench drives each branch on a falling edge and samples these outputs one nanosecond later, before the next rising edge. Link and count changes appear one edge later. The bench therefore checks them on the falling edge that follows that rising edge, once all inputs have returned to idle, so that each register check covers exactly one stimulus.

// File: rtl/branch_unit.sv
module branch_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          br_valid,
  input  logic [AW-1:0] br_pc,
  input  logic [AW-1:0] br_imm,
  input  logic [1:0]    br_src,
  input  logic          br_dec,
  input  logic [1:0]    br_cond,
  input  logic          br_link,
  input  logic          br_ext,
  input  logic          sw_we,
  input  logic          sw_sel,
  input  logic [AW-1:0] sw_data,
  output logic          br_taken,
  output logic [AW-1:0] br_target,
  output logic [AW-1:0] link_q,
  output logic [AW-1:0] count_q
);
  localparam logic [1:0] SRC_ABS = 2'd0, SRC_REL = 2'd1, SRC_LNK = 2'd2, SRC_CNT = 2'd3;
  localparam logic [1:0] TST_ZERO = 2'd1, TST_NZ = 2'd2;
  localparam logic [AW-1:0] STEP = AW'(4);

  logic [AW-1:0] link_r, count_r, raw_tgt, cnt_next;
  logic          dec_en, cnt_ok;

  assign dec_en   = br_valid & br_dec & (br_src != SRC_CNT);
  assign cnt_next = dec_en ? count_r - AW'(1) : count_r;

  always_comb begin
    case (br_cond)
      TST_ZERO: cnt_ok = (cnt_next == '0);
      TST_NZ:   cnt_ok = (cnt_next != '0);
      default:  cnt_ok = 1'b1;
    endcase
  end

  always_comb begin
    case (br_src)
      SRC_ABS: raw_tgt = br_imm;
      SRC_REL: raw_tgt = br_pc + br_imm;
      SRC_LNK: raw_tgt = link_r;
      default: raw_tgt = count_r;
    endcase
  end

  assign br_taken  = br_valid & br_ext & cnt_ok;
  assign br_target = {raw_tgt[AW-1:2], 2'b00};
  assign link_q    = link_r;
  assign count_q   = count_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_r  <= '0;
      count_r <= '0;
    end else begin
      if (sw_we && !sw_sel) link_r  <= sw_data;
      if (sw_we &&  sw_sel) count_r <= sw_data;
      if (br_valid && br_link) link_r <= br_pc + STEP;
      if (dec_en) count_r <= cnt_next;
    end
  end

  assert_tgt_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    br_target[1:0] == 2'b00);

  assert_taken_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (br_valid && br_ext));

  assert_link_save_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_link) |=> (link_q == $past(br_pc) + STEP));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_dec && br_src != SRC_CNT) |=> (count_q == $past(count_q) - AW'(1)));

  assert_cnt_src_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_src == SRC_CNT && !(sw_we && sw_sel)) |=> $stable(count_q));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid && !sw_we) |=> ($stable(count_q) && $stable(link_q)));
endmodule

// File: tb/tb_branch_unit.sv
module tb_branch_unit;
  localparam int AW = 32;
  typedef logic [AW-1:0] word_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic br_valid = 0, br_dec = 0, br_link = 0, br_ext = 0, sw_we = 0, sw_sel = 0;
  logic [1:0] br_src = 0, br_cond = 0;
  word_t br_pc = '0, br_imm = '0, sw_data = '0;
  logic br_taken;
  word_t br_target, link_q, count_q;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  branch_unit #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_pc(br_pc), .br_imm(br_imm),
    .br_src(br_src), .br_dec(br_dec), .br_cond(br_cond), .br_link(br_link), .br_ext(br_ext),
    .sw_we(sw_we), .sw_sel(sw_sel), .sw_data(sw_data),
    .br_taken(br_taken), .br_target(br_target), .link_q(link_q), .count_q(count_q));

  typedef struct packed {
    logic [1:0] src;
    word_t      pc;
    word_t      imm;
    logic       ext;
    logic [1:0] cond;
    logic       exp_taken;
    word_t      exp_tgt;
  } vec_t;

  // link preset 0x2A47, count preset 5
  localparam vec_t VEC [8] = '{
    '{2'd0, 32'h0000_0100, 32'h0000_8003, 1'b1, 2'd0, 1'b1, 32'h0000_8000},  // R1
    '{2'd1, 32'h0000_1000, 32'hFFFF_FFF0, 1'b1, 2'd0, 1'b1, 32'h0000_0FF0},  // R2
    '{2'd1, 32'h0000_2000, 32'h0000_0106, 1'b0, 2'd0, 1'b0, 32'h0000_2104},  // R2 R10
    '{2'd2, 32'h0000_0000, 32'h0000_0000, 1'b1, 2'd0, 1'b1, 32'h0000_2A44},  // R3
    '{2'd3, 32'h0000_0000, 32'h0000_0000, 1'b1, 2'd3, 1'b1, 32'h0000_0004},  // R4
    '{2'd0, 32'h0000_0000, 32'h0000_0041, 1'b1, 2'd1, 1'b0, 32'h0000_0040},  // R8
    '{2'd0, 32'h0000_0000, 32'h0000_0042, 1'b1, 2'd2, 1'b1, 32'h0000_0040},  // R8
    '{2'd1, 32'hFFFF_FFFC, 32'h0000_000B, 1'b1, 2'd0, 1'b1, 32'h0000_0004}   // R2 R5
  };

  task automatic chk(input string req, input word_t act, input word_t exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    br_valid = 0; br_dec = 0; br_link = 0; br_ext = 0; br_src = 0; br_cond = 0;
    br_pc = '0; br_imm = '0; sw_we = 0; sw_sel = 0; sw_data = '0;
  endtask

  // called on a falling edge; returns on the next falling edge, inputs idle
  task automatic tick();
    @(posedge clk); #1; idle(); @(negedge clk);
  endtask

  task automatic sw_write(input logic sel, input word_t d);
    sw_we = 1; sw_sel = sel; sw_data = d; tick();
  endtask

  task automatic branch(input logic [1:0] src, input word_t pc, input word_t imm,
                        input logic ext, input logic dec, input logic [1:0] cond, input logic lnk);
    br_valid = 1; br_src = src; br_pc = pc; br_imm = imm; br_ext = ext;
    br_dec = dec; br_cond = cond; br_link = lnk; #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    chk("R12 link", link_q, '0);
    chk("R12 count", count_q, '0);
    chk("R10 idle taken", word_t'(br_taken), '0);
    rst_n = 1;
    @(negedge clk);

    sw_write(1'b0, 32'h0000_2A47);
    chk("R11 sw link", link_q, 32'h0000_2A47);
    sw_write(1'b1, 32'h0000_0005);
    chk("R11 sw count", count_q, 32'h0000_0005);

    foreach (VEC[i]) begin
      branch(VEC[i].src, VEC[i].pc, VEC[i].imm, VEC[i].ext, 1'b0, VEC[i].cond, 1'b0);
      chk($sformatf("R1-vec%0d target R5", i), br_target, VEC[i].exp_tgt);
      chk($sformatf("R10 vec%0d taken R8", i), word_t'(br_taken), word_t'(VEC[i].exp_taken));
      tick();
    end
    chk("R9 table left count", count_q, 32'h0000_0005);

    // R7 R8: decrement then test for nonzero
    sw_write(1'b1, 32'h0000_0002);
    branch(2'd0, '0, 32'h100, 1'b1, 1'b1, 2'd2, 1'b0);
    chk("R8 dec nonzero taken", word_t'(br_taken), 1);
    tick();
    chk("R7 count 2->1", count_q, 32'h1);
    branch(2'd0, '0, 32'h100, 1'b1, 1'b1, 2'd1, 1'b0);
    chk("R8 dec zero taken", word_t'(br_taken), 1);
    tick();
    chk("R7 count 1->0", count_q, 32'h0);
    // R7 not taken still decrements, wraps from zero
    branch(2'd1, 32'h40, 32'h8, 1'b0, 1'b1, 2'd0, 1'b0);
    chk("R10 ext low not taken", word_t'(br_taken), 0);
    tick();
    chk("R7 wrap decrement", count_q, 32'hFFFF_FFFF);

    // R6 link save on not-taken branch
    branch(2'd0, 32'h0000_3000, 32'h10, 1'b0, 1'b0, 2'd0, 1'b1);
    tick();
    chk("R6 link saved", link_q, 32'h0000_3004);
    branch(2'd2, 32'h0000_5000, '0, 1'b1, 1'b0, 2'd0, 1'b1);
    chk("R3 uses old link", br_target, 32'h0000_3004);
    tick();
    chk("R6 link updated", link_q, 32'h0000_5004);

    // R9 count source ignores decrement, test uses current value
    sw_write(1'b1, 32'h0000_0007);
    branch(2'd3, '0, '0, 1'b1, 1'b1, 2'd1, 1'b0);
    chk("R9 cond on current", word_t'(br_taken), 0);
    chk("R4 count target", br_target, 32'h0000_0004);
    tick();
    chk("R9 count unchanged", count_q, 32'h0000_0007);

    // R11 collisions
    branch(2'd0, 32'h0000_0500, '0, 1'b1, 1'b0, 2'd0, 1'b1);
    sw_we = 1; sw_sel = 0; sw_data = 32'h000A_AAA0;
    tick();
    chk("R11 branch beats sw link", link_q, 32'h0000_0504);
    branch(2'd0, '0, '0, 1'b1, 1'b1, 2'd0, 1'b0);
    sw_we = 1; sw_sel = 1; sw_data = 32'h0000_0099;
    tick();
    chk("R11 branch beats sw count", count_q, 32'h0000_0006);
    branch(2'd0, 32'h0000_0800, '0, 1'b1, 1'b0, 2'd0, 1'b1);
    sw_we = 1; sw_sel = 1; sw_data = 32'h0000_0099;
    tick();
    chk("R11 sw count alongside link", count_q, 32'h0000_0099);
    chk("R6 link alongside sw", link_q, 32'h0000_0804);

    // R10 invalid branch has no effect
    br_valid = 0; br_ext = 1; br_dec = 1; br_link = 1; br_pc = 32'h700; #1;
    chk("R10 invalid not taken", word_t'(br_taken), 0);
    tick();
    chk("R10 count kept", count_q, 32'h0000_0099);
    chk("R10 link kept", link_q, 32'h0000_0804);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule